// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single line. A free-running sample tick, sixteen ticks per bit period, paces it. A low level seen while idle starts a frame. The start is confirmed half a bit later, and the data bits are then sampled in the middle of each bit period. An optional parity bit follows, then one or two stop bits. The received word moves from an internal shift register into a separate receive data register.

Four status flags report the outcome of each frame: data-full, overrun, framing error and parity error. Each kind of error has its own rule for whether the word is transferred. While any error flag is set, the receiver ignores new start bits. Software clears each flag with its own single-cycle clear input. Reading the data register has no side effect.

Two interrupt requests come out of the block: one for data-full and one for any error. One receive interrupt enable gates both. The data register is a plain register with a status flag, not a stream, so there is no valid/ready handshake. Back-pressure appears only as the overrun rule: a frame that completes while data-full is set is dropped and flagged.

Top module: `async_rx_core`

## Requirements
- R1: A start is taken when the line is low at a sample tick while idle. It is confirmed only if the line is still low 8 ticks later, otherwise the receiver returns to idle without receiving anything.
- R2: Data bits are sampled every 16 ticks and stored least significant bit first. With `cfg_short_i`=1 the word is 7 bits and bit 7 of `rdata_o` reads 0; with 0 it is 8 bits.
- R3: With `cfg_par_en_i`=1, the bit after the data is parity. If the count of ones over the data and parity bit is odd when `cfg_par_odd_i`=0 (even parity), or even when it is 1 (odd parity), `par_err_o` sets, the word is copied to `rdata_o`, and `full_o` stays 0.
- R4: If the first stop bit is 0, `frm_err_o` sets, the word is copied, and `full_o` stays 0. With `cfg_two_stop_i`=1 the second stop bit is not checked. With parity disabled, the bit after the data is the first stop bit.
- R5: A frame with no error that ends while `full_o`=0 copies its word to `rdata_o` and sets `full_o`.
- R6: A frame that ends while `full_o`=1 sets `ovr_err_o` and leaves `rdata_o` and `full_o` unchanged.
- R7: While any of `ovr_err_o`, `frm_err_o`, `par_err_o` is 1, start bits are ignored: no flag and no data changes.
- R8: A one-cycle pulse on `clr_full_i`, `clr_ovr_i`, `clr_frm_i` or `clr_par_i` clears the matching flag. A flag being set in the same cycle wins over its clear.
- R9: `rxi_o` = `full_o` AND `rie_i`. `eri_o` = (any error flag) AND `rie_i`.
- R10: After reset all flags, both requests and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick_i | input | 1 | One-cycle sample strobe, 16 per bit |
| rxd_i | input | 1 | Serial receive line, idle high |
| cfg_short_i | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop_i | input | 1 | Two stop bits in the frame |
| rie_i | input | 1 | Receive interrupt enable |
| clr_full_i | input | 1 | Clear data-full flag |
| clr_ovr_i | input | 1 | Clear overrun flag |
| clr_frm_i | input | 1 | Clear framing-error flag |
| clr_par_i | input | 1 | Clear parity-error flag |
| rdata_o | output | 8 | Receive data register |
| full_o | output | 1 | Data-full flag |
| ovr_err_o | output | 1 | Overrun flag |
| frm_err_o | output | 1 | Framing-error flag |
| par_err_o | output | 1 | Parity-error flag |
| rxi_o | output | 1 | Data-full interrupt request |
| eri_o | output | 1 | Receive-error interrupt request |

## Verification
A framer that loses bit alignment shows up one frame later. `rdata_o` then holds shifted or corrupted bits, and a framing or parity flag appears where a clean frame was sent. A bad start-confirm decision shows as a received word or flag after a short low glitch. Wrong flag bookkeeping shows within a cycle of the frame end: `full_o` rises where an error flag should, or `rdata_o` moves under an overrun. A missed blocking rule shows as flags or data changing while an error is pending.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_STOP2
  } rx_state_e;
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rxs_framer.sv
module rxs_framer
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              en_i,
  input  logic              short_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic              ferr_o,
  output logic              perr_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OSR - 1);

  rx_state_e         st_q;
  logic [CW-1:0]     tcnt_q;
  logic [BW-1:0]     bidx_q;
  logic [DATA_W-1:0] sh_q;
  logic              parb_q;
  logic [BW-1:0]     last_idx;
  logic              at_end;

  assign last_idx = short_i ? BW'(DATA_W - 2) : BW'(DATA_W - 1);
  assign at_end   = tick_i && (tcnt_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      parb_q <= 1'b0;
      done_o <= 1'b0;
      ferr_o <= 1'b0;
      perr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i && st_q != RX_IDLE) tcnt_q <= tcnt_q + 1'b1;
      unique case (st_q)
        RX_IDLE: if (tick_i && en_i && !line_i) begin
          st_q   <= RX_START;
          tcnt_q <= '0;
          sh_q   <= '0;
          parb_q <= 1'b0;
        end
        RX_START: if (tick_i && tcnt_q == MID) begin
          tcnt_q <= '0;
          bidx_q <= '0;
          st_q   <= line_i ? RX_IDLE : RX_DATA;
        end
        RX_DATA: if (at_end) begin
          sh_q[bidx_q] <= line_i;
          if (bidx_q == last_idx) st_q <= par_en_i ? RX_PAR : RX_STOP;
          else                    bidx_q <= bidx_q + 1'b1;
        end
        RX_PAR: if (at_end) begin
          parb_q <= line_i;
          st_q   <= RX_STOP;
        end
        RX_STOP: if (at_end) begin
          done_o <= 1'b1;
          ferr_o <= !line_i;
          perr_o <= par_en_i && ((^sh_q ^ parb_q) != par_odd_i);
          st_q   <= two_stop_i ? RX_STOP2 : RX_IDLE;
        end
        RX_STOP2: if (at_end) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign word_o = sh_q;
endmodule

// File: rtl/rxs_status.sv
module rxs_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              ferr_i,
  input  logic              perr_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              clr_full_i,
  input  logic              clr_ovr_i,
  input  logic              clr_frm_i,
  input  logic              clr_par_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              frm_o,
  output logic              par_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      full_o  <= 1'b0;
      ovr_o   <= 1'b0;
      frm_o   <= 1'b0;
      par_o   <= 1'b0;
    end else begin
      if (clr_full_i) full_o <= 1'b0;
      if (clr_ovr_i)  ovr_o  <= 1'b0;
      if (clr_frm_i)  frm_o  <= 1'b0;
      if (clr_par_i)  par_o  <= 1'b0;
      if (done_i) begin
        if (full_o) begin
          ovr_o <= 1'b1;
        end else begin
          rdata_o <= word_i;
          if (ferr_i || perr_i) begin
            if (ferr_i) frm_o <= 1'b1;
            if (perr_i) par_o <= 1'b1;
          end else begin
            full_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_tick_i,
  input  logic              rxd_i,
  input  logic              cfg_short_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_two_stop_i,
  input  logic              rie_i,
  input  logic              clr_full_i,
  input  logic              clr_ovr_i,
  input  logic              clr_frm_i,
  input  logic              clr_par_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              par_err_o,
  output logic              rxi_o,
  output logic              eri_o
);
  logic              line_s;
  logic              done_w, ferr_w, perr_w;
  logic [DATA_W-1:0] word_w;
  logic              any_err;

  assign any_err = ovr_err_o | frm_err_o | par_err_o;

  rxs_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(line_s)
  );

  rxs_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick_i(smp_tick_i), .line_i(line_s),
    .en_i(!any_err), .short_i(cfg_short_i), .par_en_i(cfg_par_en_i),
    .par_odd_i(cfg_par_odd_i), .two_stop_i(cfg_two_stop_i),
    .done_o(done_w), .ferr_o(ferr_w), .perr_o(perr_w), .word_o(word_w)
  );

  rxs_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .done_i(done_w), .ferr_i(ferr_w),
    .perr_i(perr_w), .word_i(word_w), .clr_full_i(clr_full_i),
    .clr_ovr_i(clr_ovr_i), .clr_frm_i(clr_frm_i), .clr_par_i(clr_par_i),
    .rdata_o(rdata_o), .full_o(full_o), .ovr_o(ovr_err_o),
    .frm_o(frm_err_o), .par_o(par_err_o)
  );

  assign rxi_o = full_o & rie_i;
  assign eri_o = any_err & rie_i;
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rie_i,
  input logic              clr_full_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              full_o,
  input logic              ovr_err_o,
  input logic              frm_err_o,
  input logic              par_err_o,
  input logic              rxi_o,
  input logic              eri_o
);
  AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err_o) |-> ($stable(rdata_o) && full_o)); // R6
  AST_ERR_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frm_err_o) || $rose(par_err_o)) |-> !$rose(full_o)); // R3
  AST_BLOCKED_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err_o || frm_err_o || par_err_o) |=> !$rose(full_o)); // R7
  AST_CLR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_full_i && full_o) |=> !full_o); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rie_i |-> (!rxi_o && !eri_o)); // R9
endmodule

bind async_rx_core rxs_chk #(.DATA_W(DATA_W)) u_rxs_chk (
  .clk(clk), .rst_n(rst_n), .rie_i(rie_i), .clr_full_i(clr_full_i),
  .rdata_o(rdata_o), .full_o(full_o), .ovr_err_o(ovr_err_o),
  .frm_err_o(frm_err_o), .par_err_o(par_err_o), .rxi_o(rxi_o), .eri_o(eri_o)
);

// File: tb/async_rx_core_tb.sv
module async_rx_core_tb_top;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_tick_i;
  logic rxd_i = 1'b1;
  logic cfg_short_i = 1'b0, cfg_par_en_i = 1'b0, cfg_par_odd_i = 1'b0;
  logic cfg_two_stop_i = 1'b0, rie_i = 1'b1;
  logic clr_full_i = 1'b0, clr_ovr_i = 1'b0, clr_frm_i = 1'b0, clr_par_i = 1'b0;
  logic [7:0] rdata_o;
  logic full_o, ovr_err_o, frm_err_o, par_err_o, rxi_o, eri_o;
  logic [1:0] tdiv_q = '0;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) tdiv_q <= tdiv_q + 1'b1;
  assign smp_tick_i = (tdiv_q == 2'd3);

  async_rx_core dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic flags(input string req, input logic [3:0] exp);
    chk(req, {28'd0, full_o, ovr_err_o, frm_err_o, par_err_o}, {28'd0, exp});
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) rxd_i = b;
    repeat (BITC - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit short7, input bit pe,
                            input bit podd, input bit flip, input bit s1,
                            input bit two, input bit s2);
    int nb;
    logic p;
    nb = short7 ? 7 : 8;
    cfg_short_i = short7; cfg_par_en_i = pe; cfg_par_odd_i = podd;
    cfg_two_stop_i = two;
    p = (short7 ? ^d[6:0] : ^d) ^ podd ^ flip;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (pe) send_bit(p);
    send_bit(s1);
    if (two) send_bit(s2);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: clr_full_i = 1'b1;
      1: clr_ovr_i = 1'b1;
      2: clr_frm_i = 1'b1;
      default: clr_par_i = 1'b1;
    endcase
    @(negedge clk);
    clr_full_i = 1'b0; clr_ovr_i = 1'b0; clr_frm_i = 1'b0; clr_par_i = 1'b0;
  endtask

  task automatic t_reset;
    flags("R10 flags", 4'b0000);
    chk("R10 rdata", {24'd0, rdata_o}, 32'h0);
    chk("R10 irq", {30'd0, rxi_o, eri_o}, 32'h0);
  endtask

  task automatic t_good_8n1;
    send_frame(8'hA5, 0, 0, 0, 0, 1, 0, 1);
    chk("R2 R5 data 8N1", {24'd0, rdata_o}, 32'hA5);
    flags("R5 full set", 4'b1000);
    chk("R9 rxi", {31'd0, rxi_o}, 32'h1);
    pulse(0);
    flags("R8 clear full", 4'b0000);
  endtask

  task automatic t_even_ok;
    send_frame(8'h3C, 0, 1, 0, 0, 1, 0, 1);
    chk("R3 even good data", {24'd0, rdata_o}, 32'h3C);
    flags("R3 even good flags", 4'b1000);
    pulse(0);
  endtask

  task automatic t_par_err_and_block;
    send_frame(8'h81, 0, 1, 1, 1, 1, 0, 1);
    chk("R3 parity err data copied", {24'd0, rdata_o}, 32'h81);
    flags("R3 parity flag", 4'b0001);
    chk("R9 eri", {31'd0, eri_o}, 32'h1);
    send_frame(8'h42, 0, 0, 0, 0, 1, 0, 1);
    chk("R7 blocked data", {24'd0, rdata_o}, 32'h81);
    flags("R7 blocked flags", 4'b0001);
    pulse(3);
    flags("R8 clear par", 4'b0000);
  endtask

  task automatic t_frm_err;
    send_frame(8'h5E, 0, 0, 0, 0, 0, 0, 1);
    chk("R4 framing data copied", {24'd0, rdata_o}, 32'h5E);
    flags("R4 framing flag", 4'b0010);
    pulse(2);
    flags("R8 clear frm", 4'b0000);
  endtask

  task automatic t_two_stop;
    send_frame(8'hC3, 0, 0, 0, 0, 1, 1, 0);
    chk("R4 second stop ignored data", {24'd0, rdata_o}, 32'hC3);
    flags("R4 second stop ignored flags", 4'b1000);
  endtask

  task automatic t_overrun;
    send_frame(8'h99, 0, 0, 0, 0, 1, 0, 1);
    chk("R6 overrun keeps data", {24'd0, rdata_o}, 32'hC3);
    flags("R6 overrun flags", 4'b1100);
    pulse(1);
    pulse(0);
    flags("R8 clear ovr full", 4'b0000);
  endtask

  task automatic t_glitch;
    @(negedge clk) rxd_i = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd_i = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    flags("R1 glitch rejected", 4'b0000);
    chk("R1 glitch data", {24'd0, rdata_o}, 32'hC3);
    send_frame(8'h6B, 0, 0, 0, 0, 1, 0, 1);
    chk("R1 after glitch data", {24'd0, rdata_o}, 32'h6B);
    pulse(0);
  endtask

  task automatic t_seven_bit;
    send_frame(8'hD5, 1, 1, 0, 0, 1, 0, 1);
    chk("R2 7-bit data", {24'd0, rdata_o}, 32'h55);
    flags("R2 7-bit flags", 4'b1000);
    rie_i = 1'b0;
    #1;
    chk("R9 rie off", {30'd0, rxi_o, eri_o}, 32'h0);
    rie_i = 1'b1;
    pulse(0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_good_8n1();
    t_even_ok();
    t_par_err_and_block();
    t_frm_err();
    t_two_stop();
    t_overrun();
    t_glitch();
    t_seven_bit();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule